// File: doc/BRIEF.md
# Multiplexed MDIO Management Master

This block is a memory-mapped management controller that runs MDIO transactions on one of several child buses. Software programs a parameter word (child bus, PHY address, write data, clause select) and an address word, then issues a start command through a control word. The block serialises a Clause 22 frame, or a Clause 45 address frame followed by a data frame, on the chosen child bus. When the last frame ends it raises a done flag in the status word. For reads, the 16 bits returned by the PHY are captured into a read-data word.

The child buses fall into two groups, internal and external, each with its own count. A selection bit in the parameter word picks the group and a 3-bit index picks the bus within it. The selection is latched when a transaction starts. Only the latched bus sees a toggling MDC and a driven MDIO. MDC runs at the system clock divided by twice `CLK_DIV`. MDIO changes only after MDC falls and is sampled when MDC rises.

Top module: `mdio_mux_master`

## Requirements
- R1: Registers sit at byte offsets 0x00 parameter, 0x04 read data, 0x08 address, 0x0C control, 0x10 status. All reset to zero. The parameter and address words read back as written. Control reads as zero.
- R2: Writing 1 to control with the clause bit (parameter bit 21) clear sends 32 ones, then MSB first: start 01, opcode 01, PHY address (parameter bits 20:16), register (address bits 4:0), turnaround 10, and data (parameter bits 15:0). The master drives all 64 bits.
- R3: Writing 2 to control with bit 21 clear sends the same frame with opcode 10. The master drives only the preamble and the first 14 frame bits, then releases MDIO for the last 18 bits. The 16 bits sampled in the data phase, MSB first, appear in read data bits 15:0, with bits 31:16 zero.
- R4: With bit 21 set, a transaction is two frames with start 00. The first carries opcode 00, device address (address bits 20:16), turnaround 10 and address bits 15:0. The second carries opcode 01 with the write data, or opcode 11 for a read, released as in R3.
- R5: Status bit 0 becomes 1 once the last frame of a transaction ends. Writing 0 to control clears it. Accepting a start also clears it.
- R6: Control writes other than 0 are ignored while a transaction runs. Values other than 0, 1 and 2 are always ignored.
- R7: Parameter bit 25 = 1 selects internal bus number bits 24:22, which is output line index. Bit 25 = 0 selects external bus bits 24:22, which is line NUM_INT plus that index. The selection is latched at start. All other lines hold MDC low and MDIO released.
- R8: An index at or beyond its group's count drives no line. The transaction still completes, and a read returns 0xFFFF.
- R9: MDC has a period of 2*CLK_DIV clocks, starting low. The driven MDIO bit changes only right after MDC falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset of the accessed register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data at reg_addr |
| mdc_o | output | NUM_INT+NUM_EXT | MDC per child bus |
| mdio_o | output | NUM_INT+NUM_EXT | MDIO output value per child bus |
| mdio_oe | output | NUM_INT+NUM_EXT | MDIO output enable per child bus |
| mdio_i | input | NUM_INT+NUM_EXT | MDIO input per child bus |

## Verification
A wrong bit counter or frame word shows up within one frame as a mismatched 64-bit pattern, or as wrong release bits on the observed bus. A lost or wrong bus latch shows up at the first MDC rising edge as clock activity on the wrong line. A broken divider shows up as a wrong interval between rising edges. A broken capture path or done flag appears in read data or status as soon as the transaction ends.

// File: rtl/mdio_mux_pkg.sv
package mdio_mux_pkg;
  localparam logic [4:0] OFS_PARAM = 5'h00;
  localparam logic [4:0] OFS_RDATA = 5'h04;
  localparam logic [4:0] OFS_ADDR  = 5'h08;
  localparam logic [4:0] OFS_CTRL  = 5'h0C;
  localparam logic [4:0] OFS_STAT  = 5'h10;

  localparam logic [31:0] CMD_CLR = 32'd0;
  localparam logic [31:0] CMD_WR  = 32'd1;
  localparam logic [31:0] CMD_RD  = 32'd2;

  // 32-bit frame body after the preamble, MSB leaves first
  function automatic logic [31:0] mk_frame(logic [1:0] st, logic [1:0] op,
                                           logic [4:0] pa, logic [4:0] ra,
                                           logic [15:0] d);
    return {st, op, pa, ra, 2'b10, d};
  endfunction

  function automatic logic [31:0] first_frame(logic c45, logic rd, logic [4:0] pa,
                                              logic [20:0] ad, logic [15:0] wd);
    if (c45) return mk_frame(2'b00, 2'b00, pa, ad[20:16], ad[15:0]);
    return mk_frame(2'b01, rd ? 2'b10 : 2'b01, pa, ad[4:0], wd);
  endfunction

  function automatic logic [31:0] second_frame(logic rd, logic [4:0] pa,
                                               logic [20:0] ad, logic [15:0] wd);
    return mk_frame(2'b00, rd ? 2'b11 : 2'b01, pa, ad[20:16], wd);
  endfunction

  // bit position 0..63 within preamble + body
  function automatic logic serial_bit(logic [31:0] frm, logic [5:0] pos);
    if (!pos[5]) return 1'b1;
    return frm[~pos[4:0]];
  endfunction
endpackage

// File: rtl/mdio_reg_file.sv
module mdio_reg_file
  import mdio_mux_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        busy_i,
  input  logic        fin_i,
  input  logic [15:0] cap_i,
  output logic        start_o,
  output logic        rd_o,
  output logic        c45_o,
  output logic        int_o,
  output logic [2:0]  idx_o,
  output logic [4:0]  phy_o,
  output logic [15:0] wdat_o,
  output logic [20:0] addr_o
);
  logic [31:0] param_q, addr_q;
  logic [15:0] rdat_q;
  logic        done_q, pend_rd_q;
  logic        ctrl_wr, clear_wr;

  assign ctrl_wr  = reg_we && (reg_addr == OFS_CTRL);
  assign clear_wr = ctrl_wr && (reg_wdata == CMD_CLR);
  assign start_o  = ctrl_wr && !busy_i && ((reg_wdata == CMD_WR) || (reg_wdata == CMD_RD));
  assign rd_o     = (reg_wdata == CMD_RD);

  assign wdat_o = param_q[15:0];
  assign phy_o  = param_q[20:16];
  assign c45_o  = param_q[21];
  assign idx_o  = param_q[24:22];
  assign int_o  = param_q[25];
  assign addr_o = addr_q[20:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      param_q   <= '0;
      addr_q    <= '0;
      rdat_q    <= '0;
      done_q    <= 1'b0;
      pend_rd_q <= 1'b0;
    end else begin
      if (reg_we && reg_addr == OFS_PARAM) param_q <= reg_wdata;
      if (reg_we && reg_addr == OFS_ADDR)  addr_q  <= reg_wdata;
      if (start_o) pend_rd_q <= rd_o;
      if (fin_i && pend_rd_q) rdat_q <= cap_i;
      if (start_o)       done_q <= 1'b0;
      else if (fin_i)    done_q <= 1'b1;
      else if (clear_wr) done_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_PARAM: reg_rdata = param_q;
      OFS_RDATA: reg_rdata = {16'h0000, rdat_q};
      OFS_ADDR:  reg_rdata = addr_q;
      OFS_STAT:  reg_rdata = {31'd0, done_q};
      default:   reg_rdata = '0;
    endcase
  end

  AST_DONE_ON_FIN: assert property (@(posedge clk) disable iff (!rst_n)
    fin_i |=> done_q); // R5
  AST_CLEAR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_wr && !fin_i) |=> !done_q); // R5
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !done_q); // R5
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mux_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        rd_i,
  input  logic        c45_i,
  input  logic [4:0]  phy_i,
  input  logic [20:0] addr_i,
  input  logic [15:0] wdat_i,
  input  logic        mdi_i,
  output logic        busy_o,
  output logic        fin_o,
  output logic        mdc_o,
  output logic        mdo_o,
  output logic        oe_o,
  output logic [15:0] cap_o
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(CLK_DIV - 1);
  localparam logic [5:0] REL_POS = 6'd46;
  localparam logic [5:0] CAP_POS = 6'd48;

  logic          busy_q, mdc_q, c45_q, rd_q, sec_q;
  logic [CW-1:0] div_q;
  logic [5:0]    bit_q;
  logic [31:0]   frm_q, frm2_q;
  logic [15:0]   cap_q;
  logic          half_end, rise_ev, fall_ev, last_bit, frame_rd, last_frame;

  assign half_end   = busy_q && (div_q == DIV_LAST);
  assign rise_ev    = half_end && !mdc_q;
  assign fall_ev    = half_end && mdc_q;
  assign last_bit   = (bit_q == 6'd63);
  assign last_frame = !c45_q || sec_q;
  assign frame_rd   = rd_q && last_frame;
  assign fin_o      = fall_ev && last_bit && last_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; mdc_q <= 1'b0; c45_q <= 1'b0; rd_q <= 1'b0; sec_q <= 1'b0;
      div_q <= '0; bit_q <= '0; frm_q <= '0; frm2_q <= '0; cap_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1; mdc_q <= 1'b0; div_q <= '0; bit_q <= '0;
      c45_q <= c45_i; rd_q <= rd_i; sec_q <= 1'b0; cap_q <= '0;
      frm_q  <= first_frame(c45_i, rd_i, phy_i, addr_i, wdat_i);
      frm2_q <= second_frame(rd_i, phy_i, addr_i, wdat_i);
    end else if (half_end) begin
      div_q <= '0;
      if (rise_ev) begin
        mdc_q <= 1'b1;
        if (frame_rd && bit_q >= CAP_POS) cap_q <= {cap_q[14:0], mdi_i};
      end else begin
        mdc_q <= 1'b0;
        if (!last_bit)       bit_q <= bit_q + 6'd1;
        else if (!last_frame) begin
          sec_q <= 1'b1; frm_q <= frm2_q; bit_q <= '0;
        end else             busy_q <= 1'b0;
      end
    end else if (busy_q) begin
      div_q <= div_q + CW'(1);
    end
  end

  assign busy_o = busy_q;
  assign mdc_o  = mdc_q;
  assign mdo_o  = busy_q && serial_bit(frm_q, bit_q);
  assign oe_o   = busy_q && !(frame_rd && bit_q >= REL_POS);
  assign cap_o  = cap_q;

  AST_MDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$stable(mdo_o)) |-> $past(fall_ev)); // R9
  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mdc_o); // R9
endmodule

// File: rtl/mdio_bus_steer.sv
module mdio_bus_steer #(
  parameter int NUM_INT = 2,
  parameter int NUM_EXT = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic                        int_i,
  input  logic [2:0]                  idx_i,
  input  logic                        mdc_i,
  input  logic                        mdo_i,
  input  logic                        oe_i,
  output logic [NUM_INT+NUM_EXT-1:0]  mdc_o,
  output logic [NUM_INT+NUM_EXT-1:0]  mdio_o,
  output logic [NUM_INT+NUM_EXT-1:0]  mdio_oe,
  input  logic [NUM_INT+NUM_EXT-1:0]  mdio_i,
  output logic                        mdi_o
);
  localparam int NB = NUM_INT + NUM_EXT;
  localparam int LW = (NB > 1) ? $clog2(NB) : 1;

  function automatic logic idx_ok(logic is_int, logic [2:0] idx);
    return is_int ? (int'(idx) < NUM_INT) : (int'(idx) < NUM_EXT);
  endfunction

  function automatic logic [LW-1:0] line_of(logic is_int, logic [2:0] idx);
    return is_int ? LW'(int'(idx)) : LW'(int'(idx) + NUM_INT);
  endfunction

  logic          valid_q;
  logic [LW-1:0] line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      line_q  <= '0;
    end else if (start_i) begin
      valid_q <= idx_ok(int_i, idx_i);
      line_q  <= line_of(int_i, idx_i);
    end
  end

  for (genvar k = 0; k < NB; k++) begin : g_line
    logic hit;
    assign hit        = valid_q && (line_q == LW'(k));
    assign mdc_o[k]   = hit && mdc_i;
    assign mdio_o[k]  = hit && mdo_i;
    assign mdio_oe[k] = hit && oe_i;
  end

  assign mdi_o = valid_q ? mdio_i[line_q] : 1'b1;

  AST_ONE_MDC: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mdc_o)); // R7
  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mdio_oe)); // R7
  AST_BAD_IDX_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> ($countones(mdc_o) == 0 && $countones(mdio_oe) == 0)); // R8
endmodule

// File: rtl/mdio_mux_master.sv
module mdio_mux_master #(
  parameter int NUM_INT = 2,
  parameter int NUM_EXT = 2,
  parameter int CLK_DIV = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_we,
  input  logic [4:0]                 reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  output logic [NUM_INT+NUM_EXT-1:0] mdc_o,
  output logic [NUM_INT+NUM_EXT-1:0] mdio_o,
  output logic [NUM_INT+NUM_EXT-1:0] mdio_oe,
  input  logic [NUM_INT+NUM_EXT-1:0] mdio_i
);
  logic        start, rd, c45, is_int, busy, fin, mdc, mdo, oe, mdi;
  logic [2:0]  idx;
  logic [4:0]  phy;
  logic [15:0] wdat, cap;
  logic [20:0] addr;

  mdio_reg_file i_regs (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .busy_i(busy), .fin_i(fin), .cap_i(cap),
    .start_o(start), .rd_o(rd), .c45_o(c45), .int_o(is_int), .idx_o(idx),
    .phy_o(phy), .wdat_o(wdat), .addr_o(addr)
  );

  mdio_frame_engine #(.CLK_DIV(CLK_DIV)) i_engine (
    .clk, .rst_n, .start_i(start), .rd_i(rd), .c45_i(c45), .phy_i(phy),
    .addr_i(addr), .wdat_i(wdat), .mdi_i(mdi),
    .busy_o(busy), .fin_o(fin), .mdc_o(mdc), .mdo_o(mdo), .oe_o(oe), .cap_o(cap)
  );

  mdio_bus_steer #(.NUM_INT(NUM_INT), .NUM_EXT(NUM_EXT)) i_steer (
    .clk, .rst_n, .start_i(start), .int_i(is_int), .idx_i(idx),
    .mdc_i(mdc), .mdo_i(mdo), .oe_i(oe),
    .mdc_o, .mdio_o, .mdio_oe, .mdio_i, .mdi_o(mdi)
  );

  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R6
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R6
endmodule

// File: tb/test_mdio_mux_master.sv
module test_mdio_mux_master;
  localparam int NUM_INT = 2;
  localparam int NUM_EXT = 2;
  localparam int CLK_DIV = 2;
  localparam int NB = NUM_INT + NUM_EXT;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NB-1:0] mdc_o, mdio_o, mdio_oe;
  logic [NB-1:0] mdio_i = '1;

  mdio_mux_master #(.NUM_INT(NUM_INT), .NUM_EXT(NUM_EXT), .CLK_DIV(CLK_DIV)) i_mdio_mux_master (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .mdc_o, .mdio_o, .mdio_oe, .mdio_i
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, frames_seen = 0, steer_bad = 0, per_bad = 0;
  bit all_done = 1'b0;
  int exp_bus[$];
  logic [63:0] exp_val[$], exp_msk[$];
  string exp_tag[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] resp(input int k);
    return 16'hA5C3 ^ (16'(k) * 16'h1111);
  endfunction

  task automatic push_frame(input int bus, input logic [1:0] st, input logic [1:0] op,
                            input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d,
                            input bit rd, input string tag);
    logic [63:0] v, m;
    v = {32'hFFFF_FFFF, st, op, pa, ra, 2'b10, d};
    m = '1;
    if (rd) begin v[17:0] = '0; m[17:0] = '0; end
    exp_bus.push_back(bus); exp_val.push_back(v); exp_msk.push_back(m); exp_tag.push_back(tag);
  endtask

  // monitor: rebuilds each frame from rising MDC edges and drives PHY replies
  logic [NB-1:0] mdc_prev = '0;
  int mon_cnt = 0, mon_bus = 0, fall_cnt = 0, last_rise = 0;
  logic [63:0] mon_val = '0, mon_msk = '0;
  always @(posedge clk) cyc++;
  always @(negedge clk) begin
    if (rst_n) begin
      if ($countones(mdc_o) > 1 || $countones(mdio_oe) > 1) steer_bad++;
      for (int k = 0; k < NB; k++) begin
        if (mdc_o[k] && !mdc_prev[k]) begin
          if (mon_cnt == 0) mon_bus = k;
          else begin
            if (mon_bus != k) steer_bad++;
            if (cyc - last_rise != 2 * CLK_DIV) per_bad++;
          end
          last_rise = cyc;
          mon_val = {mon_val[62:0], mdio_oe[k] & mdio_o[k]};
          mon_msk = {mon_msk[62:0], mdio_oe[k]};
          mon_cnt++;
          if (mon_cnt == 64) begin
            mon_cnt = 0;
            frames_seen++;
            if (exp_bus.size() == 0) chk(1'b0, "R7 unexpected frame", mon_val, 64'h0);
            else begin
              int b;
              logic [63:0] ev, em;
              string t;
              b = exp_bus.pop_front(); ev = exp_val.pop_front();
              em = exp_msk.pop_front(); t = exp_tag.pop_front();
              chk(b == mon_bus, {t, " bus"}, 64'(mon_bus), 64'(b));
              chk(ev == mon_val && em == mon_msk, t, mon_val, ev);
              chk(em == mon_msk, {t, " release"}, mon_msk, em);
            end
          end
        end
        if (!mdc_o[k] && mdc_prev[k]) begin
          fall_cnt++;
          if (fall_cnt == 64) fall_cnt = 0;
          mdio_i[k] = (fall_cnt >= 48) ? resp(k)[63 - fall_cnt] : 1'b1;
        end
      end
      mdc_prev = mdc_o;
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rdd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic wait_done(input string tag);
    logic [31:0] s;
    bit got;
    got = 1'b0;
    for (int i = 0; i < 3000 && !got; i++) begin
      rdd(5'h10, s);
      got = s[0];
    end
    chk(got, {tag, " R5 done"}, 64'(got), 64'd1);
  endtask

  task automatic start_xact(input int line, input bit isint, input int idx, input bit c45,
                            input bit rd, input logic [4:0] phy, input logic [20:0] adr,
                            input logic [15:0] wd, input string tag);
    wr(5'h00, {6'd0, isint, 3'(idx), c45, phy, wd});
    wr(5'h08, 32'(adr));
    if (line >= 0) begin
      if (!c45) push_frame(line, 2'b01, rd ? 2'b10 : 2'b01, phy, adr[4:0], wd, rd, tag);
      else begin
        push_frame(line, 2'b00, 2'b00, phy, adr[20:16], adr[15:0], 1'b0, tag);
        push_frame(line, 2'b00, rd ? 2'b11 : 2'b01, phy, adr[20:16], wd, rd, tag);
      end
    end
    wr(5'h0C, rd ? 32'd2 : 32'd1);
  endtask

  task automatic end_xact(input int line, input bit rd, input string tag);
    logic [31:0] v;
    wait_done(tag);
    if (rd) begin
      rdd(5'h04, v);
      chk(v == ((line >= 0) ? {16'h0, resp(line)} : 32'h0000_FFFF), {tag, " read data"},
          64'(v), (line >= 0) ? 64'(resp(line)) : 64'hFFFF);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    if (cyc == 150000 && !all_done) begin
      checks++; errors++;
      $display("FAIL R5 watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int seen;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rdd(5'h00, v); chk(v == 0, "R1 param reset", 64'(v), 0);
    rdd(5'h04, v); chk(v == 0, "R1 rdata reset", 64'(v), 0);
    rdd(5'h08, v); chk(v == 0, "R1 addr reset", 64'(v), 0);
    rdd(5'h10, v); chk(v == 0, "R1 status reset", 64'(v), 0);
    chk(mdc_o == 0 && mdio_oe == 0, "R7 idle lines", 64'({mdc_o, mdio_oe}), 0);
    wr(5'h00, 32'hE2A5_1234); rdd(5'h00, v); chk(v == 32'hE2A5_1234, "R1 param readback", 64'(v), 64'hE2A51234);
    wr(5'h08, 32'h0013_0077); rdd(5'h08, v); chk(v == 32'h0013_0077, "R1 addr readback", 64'(v), 64'h00130077);
    rdd(5'h0C, v); chk(v == 0, "R1 control reads zero", 64'(v), 0);

    // R2 clause 22 write, internal bus 0
    wr(5'h0C, 0);
    start_xact(0, 1'b1, 0, 1'b0, 1'b0, 5'h05, 21'h13, 16'hBEEF, "R2 c22 write");
    end_xact(0, 1'b0, "R2");

    // R5 clear by writing zero
    wr(5'h0C, 0); rdd(5'h10, v); chk(v == 0, "R5 clear done", 64'(v), 0);

    // R3 clause 22 read, internal bus 1
    start_xact(1, 1'b1, 1, 1'b0, 1'b1, 5'h1F, 21'h02, 16'h0000, "R3 c22 read");
    end_xact(1, 1'b1, "R3");

    // R5 accepted start clears done even without clearing first
    start_xact(2, 1'b0, 0, 1'b1, 1'b0, 5'h0A, {5'h1E, 16'h8001}, 16'h5A3C, "R4 c45 write");
    rdd(5'h10, v); chk(v == 0, "R5 start clears done", 64'(v), 0);
    end_xact(2, 1'b0, "R4");

    // R4 clause 45 read, external bus 1
    wr(5'h0C, 0);
    start_xact(3, 1'b0, 1, 1'b1, 1'b1, 5'h11, {5'h07, 16'h0C3A}, 16'h0000, "R4 c45 read");
    end_xact(3, 1'b1, "R4");

    // R6 / R7: commands and parameter change while busy
    wr(5'h0C, 0);
    seen = frames_seen;
    start_xact(2, 1'b0, 0, 1'b0, 1'b0, 5'h01, 21'h04, 16'h1357, "R7 latched bus");
    wr(5'h00, {6'd0, 1'b1, 3'd1, 1'b0, 5'h02, 16'h0});
    wr(5'h0C, 2);
    end_xact(2, 1'b0, "R6");
    repeat (400) @(negedge clk);
    chk(frames_seen == seen + 1, "R6 busy command ignored", 64'(frames_seen - seen), 1);
    chk(exp_bus.size() == 0, "R6 no pending frames", 64'(exp_bus.size()), 0);

    // R6 undefined command value
    wr(5'h0C, 0);
    seen = frames_seen;
    wr(5'h0C, 3);
    repeat (400) @(negedge clk);
    rdd(5'h10, v); chk(v == 0, "R6 value 3 ignored status", 64'(v), 0);
    chk(frames_seen == seen, "R6 value 3 no frame", 64'(frames_seen - seen), 0);

    // R8 out-of-range internal index
    seen = frames_seen;
    start_xact(-1, 1'b1, 5, 1'b0, 1'b1, 5'h03, 21'h01, 16'h0, "R8 bad index");
    end_xact(-1, 1'b1, "R8");
    chk(frames_seen == seen, "R8 no line driven", 64'(frames_seen - seen), 0);

    chk(steer_bad == 0, "R7 single active line", 64'(steer_bad), 0);
    chk(per_bad == 0, "R9 MDC period", 64'(per_bad), 0);
    all_done = 1'b1;
    summary();
    $finish;
  end
endmodule